// File: doc/BRIEF.md
# Standby Wake-Up Controller

This block holds the processor's standby state and decides when and how the processor leaves it. Software places the core into one of four standby modes (stop, halt, deep-halt, halt-high) by writing a one-hot mode word. While a mode bit is set, the processor is held. Each cycle, the controller checks the pending non-maskable request and the maskable request vector, gated by the per-source enable vector. When a wake condition is found, the controller clears the mode bit and releases the processor.

Leaving standby and entering an interrupt routine are decided separately. After release the core always continues with the instruction that follows the mode-setting write. The controller raises a one-cycle take-interrupt strobe only if the request type, the master interrupt enable and the current 2-bit exception level allow it. A request can therefore wake the core without any interrupt entry. Exception level encoding: 0 = no interrupt in progress, 1 = maskable or software interrupt in progress, 2 = non-maskable interrupt in progress, 3 = debug-only processing.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After reset, `standby_mode` is 0 and `cpu_hold`, `cpu_release` and `take_irq` are all 0.
- R2: When `standby_mode` is 0, a write strobe whose data has exactly one bit set loads that word into `standby_mode` at the next clock edge, and `cpu_hold` goes to 1.
- R3: A write whose data is zero or has more than one bit set is ignored: `standby_mode` stays 0 and `cpu_hold` stays 0.
- R4: While in standby with `nmi_req` at 0 and no source that has both request and enable set, the mode word is kept and `cpu_release` stays 0, whatever the values of `mie` and `exc_level`.
- R5: A maskable request whose enable bit is 0 does not wake the core.
- R6: On a wake, `standby_mode` reads 0 and `cpu_release` is 1 in the same cycle, one clock edge after the wake condition is sampled. `cpu_release` lasts exactly one cycle.
- R7: A pending `nmi_req` always wakes the core, whatever the value of `mie`. Interrupt entry follows only when `exc_level` is not 3.
- R8: An enabled, pending maskable request wakes the core. Interrupt entry follows only when `mie` is 1 and `exc_level` is 0 or 1.
- R9: When interrupt entry follows, `take_irq` is 1 for exactly one cycle, one cycle after `cpu_release`. In all other cases `take_irq` stays 0.
- R10: A wake condition already present when the mode write is accepted causes release on the cycle after `standby_mode` becomes non-zero.
- R11: While the core is running (`standby_mode` is 0), requests cause no release and no `take_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | MODE_W | One-hot standby mode word |
| nmi_req | input | 1 | Pending non-maskable request |
| irq_req | input | N_SRC | Pending maskable requests |
| irq_en | input | N_SRC | Per-source enables |
| mie | input | 1 | Master interrupt enable |
| exc_level | input | 2 | Current exception level |
| standby_mode | output | MODE_W | Active standby mode bit |
| cpu_hold | output | 1 | Core held in standby |
| cpu_release | output | 1 | One-cycle release pulse |
| take_irq | output | 1 | One-cycle strobe: take the interrupt after resuming |

## Verification
The bench uses two maskable sources. Each of the four modes is combined with every value of the non-maskable flag, the two request bits, the two enable bits, the master enable and the exception level. This separates the cases that wake with interrupt entry, wake without entry, and stay asleep. It also shows whether a request that is pending but not enabled is correctly kept from waking the core. Directed cases cover malformed mode words, requests while the core runs, and a wake condition that is already present when the mode write is accepted, which checks that release comes one cycle after entry.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    LVL_IDLE     = 2'd0,
    LVL_MASKABLE = 2'd1,
    LVL_NMI      = 2'd2,
    LVL_DEBUG    = 2'd3
  } exc_level_e;

  // Non-maskable wake vectors unless the core is in debug-only processing
  function automatic logic nmi_enters(input logic [1:0] lvl);
    return lvl != LVL_DEBUG;
  endfunction

  // Maskable wake vectors only with master enable and a low level
  function automatic logic mask_enters(input logic mie, input logic [1:0] lvl);
    return mie && (lvl == LVL_IDLE || lvl == LVL_MASKABLE);
  endfunction

  function automatic logic is_one_hot(input logic [7:0] w);
    return $countones(w) == 1;
  endfunction
endpackage

// File: rtl/swc_mode_reg.sv
module swc_mode_reg #(
  parameter int unsigned MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  input  logic              clear,
  output logic [MODE_W-1:0] mode_q,
  output logic              write_ok
);
  localparam int unsigned PADW = 8 - MODE_W;

  assign write_ok = wr && (mode_q == '0) && swc_pkg::is_one_hot({{PADW{1'b0}}, wdata});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= '0;
    else if (clear)    mode_q <= '0;
    else if (write_ok) mode_q <= wdata;
  end
endmodule

// File: rtl/swc_wake_eval.sv
module swc_wake_eval #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             nmi_req,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             mie,
  input  logic [1:0]       exc_level,
  output logic             mask_hit,
  output logic             wake,
  output logic             vector
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = irq_req[g] & irq_en[g];
  end

  assign mask_hit = |hit;
  assign wake     = nmi_req | mask_hit;
  assign vector   = (nmi_req && swc_pkg::nmi_enters(exc_level)) ||
                    (mask_hit && swc_pkg::mask_enters(mie, exc_level));
endmodule

// File: rtl/swc_resume_seq.sv
module swc_resume_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic in_standby,
  input  logic wake,
  input  logic vector,
  output logic wake_fire,
  output logic release_q,
  output logic take_q
);
  logic vec_q;

  assign wake_fire = in_standby & wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b0;
      vec_q     <= 1'b0;
      take_q    <= 1'b0;
    end else begin
      release_q <= wake_fire;
      vec_q     <= wake_fire & vector;
      take_q    <= release_q & vec_q;
    end
  end
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              nmi_req,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic [N_SRC-1:0]  irq_en,
  input  logic              mie,
  input  logic [1:0]        exc_level,
  output logic [MODE_W-1:0] standby_mode,
  output logic              cpu_hold,
  output logic              cpu_release,
  output logic              take_irq
);
  logic write_ok;
  logic mask_hit;
  logic wake_any;
  logic vector_dec;
  logic wake_fire;

  swc_wake_eval #(.N_SRC(N_SRC)) u_eval (
    .nmi_req   (nmi_req),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .mie       (mie),
    .exc_level (exc_level),
    .mask_hit  (mask_hit),
    .wake      (wake_any),
    .vector    (vector_dec)
  );

  swc_resume_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_standby (cpu_hold),
    .wake       (wake_any),
    .vector     (vector_dec),
    .wake_fire  (wake_fire),
    .release_q  (cpu_release),
    .take_q     (take_irq)
  );

  swc_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (mode_wr),
    .wdata    (mode_wdata),
    .clear    (wake_fire),
    .mode_q   (standby_mode),
    .write_ok (write_ok)
  );

  assign cpu_hold = |standby_mode;
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned MODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr,
  input logic [MODE_W-1:0] mode_wdata,
  input logic              nmi_req,
  input logic [N_SRC-1:0]  irq_req,
  input logic [N_SRC-1:0]  irq_en,
  input logic [MODE_W-1:0] standby_mode,
  input logic              cpu_hold,
  input logic              cpu_release,
  input logic              take_irq,
  input logic              write_ok,
  input logic              wake_fire
);
  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(standby_mode)); // R2
  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold && mode_wr && !$onehot(mode_wdata)) |=> !cpu_hold); // R3
  AST_QUIET_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && !nmi_req && ((irq_req & irq_en) == '0)) |=> (!cpu_release && standby_mode == $past(standby_mode))); // R4
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release |-> (standby_mode == '0 && $past(cpu_hold))); // R6
  AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release |=> !cpu_release); // R6
  AST_NMI_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && nmi_req) |=> cpu_release); // R7
  AST_TAKE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(cpu_release)); // R9
  AST_RUNNING_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold && !write_ok) |=> !cpu_release); // R11
  AST_FIRE_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wake_fire |-> cpu_hold); // R11
endmodule

bind standby_wake_ctrl swc_checker #(.N_SRC(N_SRC), .MODE_W(MODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_wr      (mode_wr),
  .mode_wdata   (mode_wdata),
  .nmi_req      (nmi_req),
  .irq_req      (irq_req),
  .irq_en       (irq_en),
  .standby_mode (standby_mode),
  .cpu_hold     (cpu_hold),
  .cpu_release  (cpu_release),
  .take_irq     (take_irq),
  .write_ok     (write_ok),
  .wake_fire    (wake_fire)
);

// File: tb/test_standby_wake_ctrl.sv
module test_standby_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int MW = 4;

  logic clk = 0, rst_n = 0;
  logic mode_wr = 0;
  logic [MW-1:0] mode_wdata = '0;
  logic nmi_req = 0;
  logic [NS-1:0] irq_req = '0, irq_en = '0;
  logic mie = 0;
  logic [1:0] exc_level = '0;
  logic [MW-1:0] standby_mode;
  logic cpu_hold, cpu_release, take_irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  standby_wake_ctrl #(.N_SRC(NS), .MODE_W(MW)) i_standby_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .nmi_req(nmi_req), .irq_req(irq_req), .irq_en(irq_en), .mie(mie),
    .exc_level(exc_level), .standby_mode(standby_mode), .cpu_hold(cpu_hold),
    .cpu_release(cpu_release), .take_irq(take_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    nmi_req = 0; irq_req = '0; irq_en = '0; mie = 0; exc_level = 2'd0; mode_wr = 0;
  endtask

  // Expected entry decision, written as a case table per level
  function automatic bit exp_entry(bit n, bit m, bit ie, logic [1:0] lv);
    bit r = 0;
    case (lv)
      2'd0, 2'd1: r = n | (m & ie);
      2'd2:       r = n;
      default:    r = 0;
    endcase
    return r;
  endfunction

  // Leave standby with a non-vectoring wake
  task automatic force_exit();
    nmi_req = 1; exc_level = 2'd3;
    cyc();
    quiet();
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", standby_mode, 0);
    chk("R1 hold", cpu_hold, 0);
    chk("R1 release", cpu_release, 0);
    chk("R1 take", take_irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 malformed words
    for (int w = 0; w < 16; w++) begin
      if ($countones(w) == 1) continue;
      mode_wr = 1; mode_wdata = MW'(w);
      cyc();
      mode_wr = 0;
      chk("R3 mode", standby_mode, 0);
      chk("R3 hold", cpu_hold, 0);
    end

    // R11 requests while running
    nmi_req = 1; irq_req = '1; irq_en = '1; mie = 1;
    cyc(); cyc();
    chk("R11 release", cpu_release, 0);
    chk("R11 take", take_irq, 0);
    quiet();
    cyc();

    // R10 wake present at entry
    nmi_req = 1; exc_level = 2'd0; mode_wr = 1; mode_wdata = 4'b0100;
    cyc();
    mode_wr = 0;
    chk("R10 entered", standby_mode, 4);
    chk("R10 no early release", cpu_release, 0);
    cyc();
    chk("R10 release", cpu_release, 1);
    chk("R10 mode cleared", standby_mode, 0);
    quiet();
    cyc();
    chk("R10 take", take_irq, 1);
    cyc();
    chk("R9 take pulse", take_irq, 0);

    // Sweep: mode x nmi x req x en x mie x level
    for (int m = 0; m < MW; m++)
      for (int n = 0; n < 2; n++)
        for (int rq = 0; rq < 4; rq++)
          for (int en = 0; en < 4; en++)
            for (int me = 0; me < 2; me++)
              for (int lv = 0; lv < 4; lv++) begin
                bit mh, wk, ent;
                mh  = (rq & en) != 0;
                wk  = n || mh;
                ent = wk && exp_entry(n[0], mh, me[0], lv[1:0]);
                mode_wr = 1; mode_wdata = MW'(1 << m);
                cyc();
                mode_wr = 0;
                chk("R2 mode", standby_mode, 1 << m);
                chk("R2 hold", cpu_hold, 1);
                nmi_req = n[0]; irq_req = NS'(rq); irq_en = NS'(en);
                mie = me[0]; exc_level = lv[1:0];
                cyc();
                if (wk) begin
                  chk(n ? "R7 release" : "R8 release", cpu_release, 1);
                  chk("R6 mode cleared", standby_mode, 0);
                end else begin
                  chk(rq != 0 ? "R5 masked no wake" : "R4 no wake", cpu_release, 0);
                  chk("R4 mode kept", standby_mode, 1 << m);
                end
                quiet();
                cyc();
                chk(n ? "R7 entry" : "R8 entry", take_irq, int'(ent));
                chk("R6 release pulse", cpu_release, 0);
                if (!wk) force_exit();
                else begin
                  cyc();
                  chk("R9 take ends", take_irq, 0);
                end
              end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule